// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous memory. An edge that is not stalled and has the advance input low loads a full address from outside. Each later unstalled edge with advance high moves the two least significant bits to the next beat. The bits above the beat field pass through unchanged. After four steps the beat field comes back to the offset the burst started at.

A static order input picks one of two beat orders. Linear order counts up modulo four from the start offset. Interleaved order XORs the start offset with a beat count. The order input is fixed at power-up and is changed only while the block is held in reset. A high stall input freezes the block completely: the advance and load-address inputs are then ignored.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, the address output reads zero.
- R2: An edge with stall low and advance low loads the whole load-address input. From the next cycle the address output equals that value.
- R3: With the order input low (linear), each edge with stall low and advance high makes the two low output bits equal to (start offset + beats stepped) modulo 4.
- R4: With the order input high (interleaved), each such step makes the two low output bits equal to the start offset XOR the beats stepped modulo 4. For example, start 01 gives 01, 00, 11, 10.
- R5: After the fourth step of a burst, the output again equals the loaded address, in either order.
- R6: While stepping, the output bits above bit 1 stay at their loaded value, and the load-address input is ignored.
- R7: An edge with stall high leaves the address output unchanged, whatever the advance and load-address inputs are. The next unstalled step continues the burst from where it stopped.
- R8: A load in the middle of a burst restarts the sequence from the new address, with the beat count back at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| stall_i | input | 1 | High: hold all state and ignore other inputs |
| adv_i | input | 1 | Low: load a new address; high: step to the next beat |
| load_addr_i | input | ADDR_W | Start address of a burst, sampled on load edges |
| interleave_i | input | 1 | 0 selects linear order, 1 selects interleaved order; static |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The properties assume two things. First, the order input changes only while reset is asserted. Second, stall stays high for the synchronizer's release delay after reset is released, so the checker's view of reset never runs ahead of the registers. The stimulus meets both assumptions. It sets the order input before each reset pulse. It holds stall high for several cycles after release before any load or step. Within those limits, the sweep covers every start offset in both orders, stalls in the middle of bursts, and reloads in the middle of bursts.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } bseq_op_e;

endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[LAST];

endmodule

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
(
  input  logic     stall_i,
  input  logic     adv_i,
  output bseq_op_e op_o
);

  always_comb begin
    if (stall_i)     op_o = OP_IDLE;
    else if (!adv_i) op_o = OP_LOAD;
    else             op_o = OP_STEP;
  end

endmodule

// File: rtl/bseq_state.sv
module bseq_state
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bseq_op_e          op_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [BEAT_W-1:0] beat_o
);

  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              base_en, beat_en;

  always_comb begin
    base_en = 1'b0;
    beat_en = 1'b0;
    base_d  = base_q;
    beat_d  = beat_q;
    unique case (op_i)
      OP_LOAD: begin
        base_en = 1'b1;
        beat_en = 1'b1;
        base_d  = load_addr_i;
        beat_d  = '0;
      end
      OP_STEP: begin
        beat_en = 1'b1;
        beat_d  = beat_q + BEAT_ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign base_o = base_q;
  assign beat_o = beat_q;

endmodule

// File: rtl/bseq_offset.sv
module bseq_offset #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              interleave_i,
  output logic [BEAT_W-1:0] offset_o
);

  logic [BEAT_W-1:0] lin_off, xor_off;

  always_comb begin
    lin_off  = start_i + beat_i;
    xor_off  = start_i ^ beat_i;
    offset_o = interleave_i ? xor_off : lin_off;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BEAT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              core_rst_n;
  bseq_op_e          op;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] offset;

  bseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  bseq_decode u_dec (
    .stall_i (stall_i),
    .adv_i   (adv_i),
    .op_o    (op)
  );

  bseq_state #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_state (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .op_i        (op),
    .load_addr_i (load_addr_i),
    .base_o      (base),
    .beat_o      (beat)
  );

  bseq_offset #(.BEAT_W(BEAT_W)) u_off (
    .start_i      (base[BEAT_W-1:0]),
    .beat_i       (beat),
    .interleave_i (interleave_i),
    .offset_o     (offset)
  );

  assign addr_o = {base[ADDR_W-1 -: HI_W], offset};

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic              interleave_i,
  input logic [ADDR_W-1:0] addr_o
);

  logic [BEAT_W-1:0] ref_start_q;
  logic [BEAT_W-1:0] ref_beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_start_q <= '0;
      ref_beat_q  <= '0;
    end else if (!stall_i && !adv_i) begin
      ref_start_q <= load_addr_i[BEAT_W-1:0];
      ref_beat_q  <= '0;
    end else if (!stall_i) begin
      ref_beat_q  <= ref_beat_q + BEAT_W'(1);
    end
  end

  // R2
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !adv_i) |=> addr_o == $past(load_addr_i));

  // R7
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(addr_o));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && adv_i) |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && adv_i && !interleave_i) |=>
      addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + BEAT_W'(1));

  // R4
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && adv_i && interleave_i) |=>
      addr_o[BEAT_W-1:0] == (ref_start_q ^ ref_beat_q));

endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall_i      (stall_i),
  .adv_i        (adv_i),
  .load_addr_i  (load_addr_i),
  .interleave_i (interleave_i),
  .addr_o       (addr_o)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall_i;
  logic          adv_i;
  logic [AW-1:0] load_addr_i;
  logic          interleave_i;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_addr_seq u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_i      (stall_i),
    .adv_i        (adv_i),
    .load_addr_i  (load_addr_i),
    .interleave_i (interleave_i),
    .addr_o       (addr_o)
  );

  function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k);
    return m ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected %h", req, act, exp);
    end
  endtask

  // drive after a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cyc(input logic st, input logic av, input logic [AW-1:0] a);
    stall_i     = st;
    adv_i       = av;
    load_addr_i = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n        = 1'b0;
    interleave_i = m;
    stall_i      = 1'b1;
    adv_i        = 1'b0;
    load_addr_i  = '1;
    repeat (3) @(negedge clk);
    check("R1 in reset", addr_o, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 20'hFFFFF);
    check("R1 after release", addr_o, '0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: addr_o=%h expected run to finish", addr_o);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n        = 1'b1;
    stall_i      = 1'b1;
    adv_i        = 1'b0;
    load_addr_i  = '0;
    interleave_i = 1'b0;
    #1 rst_n = 1'b0;

    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      // sweep every start offset with several upper patterns
      for (int u = 0; u < 3; u++) begin
        for (int s = 0; s < 4; s++) begin
          logic [AW-1:0] a;
          a = {18'((u * 18'h0B5A3) ^ (s * 18'h01111) ^ (m * 18'h2AAAA)), 2'(s)};
          cyc(1'b0, 1'b0, a);
          check("R2 load", addr_o, a);
          for (int k = 1; k <= 4; k++) begin
            cyc(1'b0, 1'b1, ~a);
            if (k == 4)
              check("R5 wrap", addr_o, a);
            else if (m == 0)
              check("R3 R6 linear step", addr_o, {a[AW-1:2], exp_low(1'b0, 2'(s), k)});
            else
              check("R4 R6 interleaved step", addr_o, {a[AW-1:2], exp_low(1'b1, 2'(s), k)});
          end
        end
      end

      // stall in the middle of a burst
      begin
        logic [AW-1:0] a;
        a = 20'h3C5A1;
        cyc(1'b0, 1'b0, a);
        cyc(1'b0, 1'b1, '0);
        cyc(1'b1, 1'b0, 20'h00002);
        check("R7 stall with load", addr_o, {a[AW-1:2], exp_low(m[0], 2'b01, 1)});
        cyc(1'b1, 1'b1, 20'h12345);
        check("R7 stall with step", addr_o, {a[AW-1:2], exp_low(m[0], 2'b01, 1)});
        cyc(1'b0, 1'b1, '0);
        check("R7 resume", addr_o, {a[AW-1:2], exp_low(m[0], 2'b01, 2)});
      end

      // reload in the middle of a burst
      begin
        logic [AW-1:0] b;
        b = 20'hA0F02;
        cyc(1'b0, 1'b1, '0);
        cyc(1'b0, 1'b0, b);
        check("R8 reload", addr_o, b);
        cyc(1'b0, 1'b1, '1);
        check("R8 first step after reload", addr_o, {b[AW-1:2], exp_low(m[0], 2'b10, 1)});
        cyc(1'b0, 1'b1, '1);
        check("R8 second step after reload", addr_o, {b[AW-1:2], exp_low(m[0], 2'b10, 2)});
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule